// File: doc/BRIEF.md
# Password-Gated Memory Access Controller

This block decides whether a protected memory command may run. It holds two 64-bit access keys and one key-enable byte. The first key grants read access only. The second key grants both read and write access. Ordinary store writes load the keys and the enable byte: the block watches the store write port and captures any byte written to one of its own addresses. When a command arrives, the host streams its 64-bit pattern one byte at a time, least-significant byte first. The block compares each byte against both keys as it arrives, keeping one running match flag per key, so the host pattern is never buffered.

A memory-read command is granted when the pattern equals either key. A scratchpad-copy command needs more. The host first echoes the two target-address bytes and the end/status byte, and all three must equal the values held internally. The pattern must then equal the read/write key. A granted copy pulses a copy-done strobe and sets the copy-done status flag (AA). A scratchpad-write command clears AA. Scratchpad reads and writes are granted at once, with no key.

Key checking is active only while the enable byte holds exactly 0xAA. Any other value turns checking off, and every pattern is then accepted. After each decision the block ignores all traffic until the next bus reset.

Top module: `pw_gate_ctrl`

## Requirements
- R1: In reset the enable byte, both keys and the AA flag clear to zero, so checking starts disabled. `grant`, `deny` and `copy_done` are low.
- R2: While the enable byte is not 0xAA, any pattern is accepted. A memory read is then granted, and a copy is granted whenever its echo matches.
- R3: While the enable byte is 0xAA, a memory read (cmd_kind 1) is granted exactly when the pattern equals the read-only key or the read/write key. Otherwise it is denied.
- R4: While the enable byte is 0xAA, a copy (cmd_kind 2) is granted only when the pattern equals the read/write key. A pattern equal only to the read-only key is denied.
- R5: A copy first takes three echo bytes, in this order: address bits 7:0, address bits 15:8, and then the byte {AA, es_low[6:0]}. If any echo byte differs, the copy is denied right after the third echo byte, and no pattern bytes are taken.
- R6: Pattern byte i (i = 0 first) is compared with bits 8i+7..8i of each key. Key byte i is stored at the key's base address plus i: the read-only key at 0x7FC0 and the read/write key at 0x7FC8. The enable byte is at 0x7FD0.
- R7: A scratchpad write (cmd_kind 3) or a scratchpad read (cmd_kind 4) is granted in the cycle after the command is accepted, without any pattern bytes. Other cmd_kind values are ignored.
- R8: A granted copy pulses `copy_done` together with `grant` and sets AA. A scratchpad write clears AA. A denied copy leaves AA unchanged.
- R9: `grant` or `deny` is a single-cycle pulse in the cycle after the deciding byte is accepted. The two are never high together.
- R10: After a decision, commands and bytes are ignored until `bus_reset` is asserted. `bus_reset` returns the block to idle but keeps AA and the keys.
- R11: Store writes to addresses outside the key and enable locations leave the keys and the enable byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Returns the command sequencer to idle |
| cmd_valid | input | 1 | A command code is present |
| cmd_kind | input | 3 | 1 memory read, 2 copy, 3 scratchpad write, 4 scratchpad read |
| byte_valid | input | 1 | An echo or pattern byte is present |
| byte_data | input | 8 | Echo or pattern byte |
| ta_addr | input | 16 | Internal target address |
| es_low | input | 7 | Internal partial flag and ending offset (E/S bits 6:0) |
| st_wr_en | input | 1 | Store write strobe |
| st_wr_addr | input | 16 | Store write address |
| st_wr_data | input | 8 | Store write data |
| grant | output | 1 | Access granted pulse |
| deny | output | 1 | Access denied pulse |
| copy_done | output | 1 | Copy allowed pulse |
| aa_flag | output | 1 | Copy-done status flag (E/S bit 7) |

## Verification
The bench builds the block with its default parameters: an 8-byte key, a 16-bit address and an enable value of 0xAA. With these values every key byte position, each of the three echo positions and both the enabled and bypassed modes can be reached in short sequences. Random operations switch the enable byte on and off at random and overwrite single key bytes. This brings patterns that differ from a key in one byte only, and copies whose echo carries a stale AA value.

// File: rtl/pw_gate_pkg.sv
// Shared types for the password-gated access controller.
// Assumes command codes are fixed by the surrounding command decoder.
package pw_gate_pkg;

    // Command codes presented on cmd_kind
    localparam logic [2:0] CMD_RD_MEM = 3'd1;
    localparam logic [2:0] CMD_COPY   = 3'd2;
    localparam logic [2:0] CMD_WR_SP  = 3'd3;
    localparam logic [2:0] CMD_RD_SP  = 3'd4;

    // Number of echoed address/status bytes ahead of a copy pattern
    localparam int ECHO_BYTES = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ECHO = 2'd1,
        ST_PASS = 2'd2,
        ST_HOLD = 2'd3
    } gate_state_e;

endpackage

// File: rtl/pw_key_store.sv
// Key and enable-byte register file.
// Snoops the store write port and captures bytes whose address falls on
// a key byte or the enable location. All other addresses are ignored.
// Assumes one byte per write and a synchronous active-low reset.
module pw_key_store #(
    parameter int                  PW_BYTES = 8,
    parameter int                  ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]   RO_BASE  = 16'h7FC0,
    parameter logic [ADDR_W-1:0]   RW_BASE  = 16'h7FC8,
    parameter logic [ADDR_W-1:0]   EN_ADDR  = 16'h7FD0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    output logic [8*PW_BYTES-1:0]   ro_key,
    output logic [8*PW_BYTES-1:0]   rw_key,
    output logic [7:0]              en_byte
);

    // One register byte per key position, for both keys
    for (genvar g = 0; g < PW_BYTES; g++) begin : g_key_byte
        localparam logic [ADDR_W-1:0] RO_AT = ADDR_W'(RO_BASE + g);
        localparam logic [ADDR_W-1:0] RW_AT = ADDR_W'(RW_BASE + g);

        // Capture read-only key byte g
        always_ff @(posedge clk) begin
            if (!rst_n)
                ro_key[8*g +: 8] <= '0;
            else if (wr_en && wr_addr == RO_AT)
                ro_key[8*g +: 8] <= wr_data;
        end

        // Capture read/write key byte g
        always_ff @(posedge clk) begin
            if (!rst_n)
                rw_key[8*g +: 8] <= '0;
            else if (wr_en && wr_addr == RW_AT)
                rw_key[8*g +: 8] <= wr_data;
        end
    end

    // Capture the enable byte; reset value keeps checking off
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_byte <= 8'h00;
        else if (wr_en && wr_addr == EN_ADDR)
            en_byte <= wr_data;
    end

endmodule

// File: rtl/pw_run_match.sv
// Running byte-serial comparator for two keys.
// Holds one match flag per key. Each accepted byte ANDs in the result of
// comparing it with the key byte picked by idx, so the host pattern is
// never stored. The *_nxt outputs include the byte currently presented,
// which lets the sequencer decide in the same cycle as the last byte.
module pw_run_match #(
    parameter int PW_BYTES = 8,
    parameter int IDX_W    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    step,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              byte_in,
    input  logic [8*PW_BYTES-1:0]   ro_key,
    input  logic [8*PW_BYTES-1:0]   rw_key,
    output logic                    ro_ok_nxt,
    output logic                    rw_ok_nxt
);

    logic ro_ok;
    logic rw_ok;
    logic [7:0] ro_sel;
    logic [7:0] rw_sel;

    // Pick the key bytes for this position and fold in the new byte
    always_comb begin
        ro_sel    = ro_key[idx*8 +: 8];
        rw_sel    = rw_key[idx*8 +: 8];
        ro_ok_nxt = ro_ok && (byte_in == ro_sel);
        rw_ok_nxt = rw_ok && (byte_in == rw_sel);
    end

    // Hold the running flags; clr re-arms them before a new pattern
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ro_ok <= 1'b1;
            rw_ok <= 1'b1;
        end else if (clr) begin
            ro_ok <= 1'b1;
            rw_ok <= 1'b1;
        end else if (step) begin
            ro_ok <= ro_ok_nxt;
            rw_ok <= rw_ok_nxt;
        end
    end

endmodule

// File: rtl/pw_gate_seq.sv
// Command sequencer for the access gate.
// Takes one command, then (for a copy) the three echo bytes, then the
// pattern bytes, and issues a single grant or deny pulse. It then waits
// for bus_reset. Owns the AA status flag.
// Assumes ADDR_W is 16 (echo uses two address bytes) and PW_BYTES >= 4.
module pw_gate_seq
    import pw_gate_pkg::*;
#(
    parameter int          PW_BYTES = 8,
    parameter int          ADDR_W   = 16,
    parameter int          IDX_W    = 3,
    parameter logic [7:0]  KEY_ON   = 8'hAA
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_reset,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_kind,
    input  logic                byte_valid,
    input  logic [7:0]          byte_data,
    input  logic [ADDR_W-1:0]   ta_addr,
    input  logic [6:0]          es_low,
    input  logic [7:0]          en_byte,
    input  logic                ro_ok_nxt,
    input  logic                rw_ok_nxt,
    output logic                match_clr,
    output logic                match_step,
    output logic [IDX_W-1:0]    idx,
    output logic                grant,
    output logic                deny,
    output logic                copy_done,
    output logic                aa_flag
);

    localparam logic [IDX_W-1:0] LAST_PW   = IDX_W'(PW_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_ECHO = IDX_W'(ECHO_BYTES - 1);

    gate_state_e      st;
    logic [IDX_W-1:0] cnt;
    logic             is_copy;
    logic             echo_ok;
    logic [7:0]       echo_exp;
    logic             echo_ok_nxt;
    logic             bypass;
    logic             pw_pass;

    // Expected echo byte for the current position, and running echo match
    always_comb begin
        case (cnt)
            IDX_W'(0): echo_exp = ta_addr[7:0];
            IDX_W'(1): echo_exp = ta_addr[15:8];
            default:   echo_exp = {aa_flag, es_low};
        endcase
        echo_ok_nxt = echo_ok && (byte_data == echo_exp);
    end

    // Key verdict including the byte now presented
    always_comb begin
        bypass  = (en_byte != KEY_ON);
        pw_pass = bypass || (is_copy ? rw_ok_nxt : (ro_ok_nxt || rw_ok_nxt));
    end

    // Drive the comparator: re-arm while idle, step on pattern bytes
    always_comb begin
        match_clr  = (st == ST_IDLE);
        match_step = (st == ST_PASS) && byte_valid;
        idx        = cnt;
    end

    // Sequence commands, issue decision pulses and maintain AA
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            is_copy   <= 1'b0;
            echo_ok   <= 1'b1;
            grant     <= 1'b0;
            deny      <= 1'b0;
            copy_done <= 1'b0;
            aa_flag   <= 1'b0;
        end else begin
            grant     <= 1'b0;
            deny      <= 1'b0;
            copy_done <= 1'b0;
            if (bus_reset) begin
                st <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: begin
                        cnt     <= '0;
                        echo_ok <= 1'b1;
                        if (cmd_valid) begin
                            case (cmd_kind)
                                CMD_RD_MEM: begin
                                    is_copy <= 1'b0;
                                    st      <= ST_PASS;
                                end
                                CMD_COPY: begin
                                    is_copy <= 1'b1;
                                    st      <= ST_ECHO;
                                end
                                CMD_WR_SP: begin
                                    aa_flag <= 1'b0;
                                    grant   <= 1'b1;
                                    st      <= ST_HOLD;
                                end
                                CMD_RD_SP: begin
                                    grant <= 1'b1;
                                    st    <= ST_HOLD;
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_ECHO: begin
                        if (byte_valid) begin
                            echo_ok <= echo_ok_nxt;
                            if (cnt == LAST_ECHO) begin
                                cnt <= '0;
                                if (echo_ok_nxt) begin
                                    st <= ST_PASS;
                                end else begin
                                    deny <= 1'b1;
                                    st   <= ST_HOLD;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_PASS: begin
                        if (byte_valid) begin
                            if (cnt == LAST_PW) begin
                                st <= ST_HOLD;
                                if (pw_pass) begin
                                    grant <= 1'b1;
                                    if (is_copy) begin
                                        copy_done <= 1'b1;
                                        aa_flag   <= 1'b1;
                                    end
                                end else begin
                                    deny <= 1'b1;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pw_gate_ctrl.sv
// Top of the password-gated memory access controller.
// Joins the key store, the running comparator and the command sequencer.
// Assumes the command decoder presents one command per bus transaction
// and asserts bus_reset between transactions.
module pw_gate_ctrl #(
    parameter int PW_BYTES = 8,
    parameter int ADDR_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_reset,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_kind,
    input  logic                byte_valid,
    input  logic [7:0]          byte_data,
    input  logic [ADDR_W-1:0]   ta_addr,
    input  logic [6:0]          es_low,
    input  logic                st_wr_en,
    input  logic [ADDR_W-1:0]   st_wr_addr,
    input  logic [7:0]          st_wr_data,
    output logic                grant,
    output logic                deny,
    output logic                copy_done,
    output logic                aa_flag
);

    localparam int IDX_W = $clog2(PW_BYTES);

    logic [8*PW_BYTES-1:0] ro_key;
    logic [8*PW_BYTES-1:0] rw_key;
    logic [7:0]            en_byte;
    logic                  ro_ok_nxt;
    logic                  rw_ok_nxt;
    logic                  match_clr;
    logic                  match_step;
    logic [IDX_W-1:0]      idx;

    pw_key_store #(
        .PW_BYTES (PW_BYTES),
        .ADDR_W   (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr_en),
        .wr_addr (st_wr_addr),
        .wr_data (st_wr_data),
        .ro_key  (ro_key),
        .rw_key  (rw_key),
        .en_byte (en_byte)
    );

    pw_run_match #(
        .PW_BYTES (PW_BYTES),
        .IDX_W    (IDX_W)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (match_clr),
        .step      (match_step),
        .idx       (idx),
        .byte_in   (byte_data),
        .ro_key    (ro_key),
        .rw_key    (rw_key),
        .ro_ok_nxt (ro_ok_nxt),
        .rw_ok_nxt (rw_ok_nxt)
    );

    pw_gate_seq #(
        .PW_BYTES (PW_BYTES),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (cmd_kind),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .ta_addr    (ta_addr),
        .es_low     (es_low),
        .en_byte    (en_byte),
        .ro_ok_nxt  (ro_ok_nxt),
        .rw_ok_nxt  (rw_ok_nxt),
        .match_clr  (match_clr),
        .match_step (match_step),
        .idx        (idx),
        .grant      (grant),
        .deny       (deny),
        .copy_done  (copy_done),
        .aa_flag    (aa_flag)
    );

endmodule

// File: rtl/pw_gate_chk.sv
// Protocol checker for pw_gate_ctrl, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module pw_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_kind,
    input logic       grant,
    input logic       deny,
    input logic       copy_done,
    input logic       aa_flag
);

    // R9: a decision is either grant or deny, never both
    p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));

    // R9: decision pulses last a single cycle
    p_grant_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);

    p_deny_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        deny |=> !deny);

    // R8: copy_done only comes with a grant
    p_copy_with_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done |-> grant);

    // R8: AA rises only through a granted copy
    p_aa_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aa_flag) |-> copy_done);

    // R8: AA falls only after a scratchpad-write command
    p_aa_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aa_flag) |-> $past(cmd_valid && cmd_kind == 3'd3));

endmodule

bind pw_gate_ctrl pw_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .grant     (grant),
    .deny      (deny),
    .copy_done (copy_done),
    .aa_flag   (aa_flag)
);

// File: tb/pw_gate_ctrl_tb_top.sv
module pw_gate_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_kind = 3'd0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'd0;
    logic [15:0] ta_addr = 16'h1234;
    logic [6:0]  es_low = 7'h3F;
    logic        st_wr_en = 1'b0;
    logic [15:0] st_wr_addr = 16'd0;
    logic [7:0]  st_wr_data = 8'd0;
    logic        grant, deny, copy_done, aa_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // bench model state
    logic [63:0] m_ro = '0;
    logic [63:0] m_rw = '0;
    logic [7:0]  m_en = 8'h00;
    logic        m_aa = 1'b0;

    pw_gate_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .ta_addr(ta_addr), .es_low(es_low),
        .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
        .grant(grant), .deny(deny), .copy_done(copy_done), .aa_flag(aa_flag)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_pass(input logic [2:0] kind, input logic [63:0] pat);
        bit byp = (m_en != 8'hAA);
        if (kind == 3'd1) return byp || pat == m_ro || pat == m_rw;
        return byp || pat == m_rw;
    endfunction

    task automatic st_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        st_wr_en = 1'b1; st_wr_addr = a; st_wr_data = d;
        @(negedge clk);
        st_wr_en = 1'b0;
        if (a >= 16'h7FC0 && a <= 16'h7FC7) m_ro[8*(a-16'h7FC0) +: 8] = d;
        else if (a >= 16'h7FC8 && a <= 16'h7FCF) m_rw[8*(a-16'h7FC8) +: 8] = d;
        else if (a == 16'h7FD0) m_en = d;
    endtask

    task automatic set_key(input logic [15:0] base, input logic [63:0] k);
        for (int i = 0; i < 8; i++) st_write(base + 16'(i), k[8*i +: 8]);
    endtask

    task automatic pulse_bus_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    // Run one command; bad_echo 0 = echo correct, 1..3 = corrupt that echo byte
    task automatic run_op(input logic [2:0] kind, input logic [63:0] pat,
                          input int bad_echo, input string req);
        logic [7:0] q [11];
        int n = 0;
        bit eg, ed, ecd, eaa;
        bit echo_ok = (bad_echo == 0);
        if (kind == 3'd2) begin
            q[0] = ta_addr[7:0]; q[1] = ta_addr[15:8]; q[2] = {m_aa, es_low};
            if (bad_echo > 0) q[bad_echo-1] = q[bad_echo-1] ^ 8'h10;
            n = 3;
            if (echo_ok) begin
                for (int i = 0; i < 8; i++) q[3+i] = pat[8*i +: 8];
                n = 11;
            end
        end else if (kind == 3'd1) begin
            for (int i = 0; i < 8; i++) q[i] = pat[8*i +: 8];
            n = 8;
        end
        eaa = m_aa;
        ecd = 1'b0;
        case (kind)
            3'd1: begin eg = exp_pass(kind, pat); ed = !eg; end
            3'd2: begin
                eg = echo_ok && exp_pass(kind, pat); ed = !eg;
                if (eg) begin ecd = 1'b1; eaa = 1'b1; end
            end
            3'd3: begin eg = 1'b1; ed = 1'b0; eaa = 1'b0; end
            3'd4: begin eg = 1'b1; ed = 1'b0; end
            default: begin eg = 1'b0; ed = 1'b0; end
        endcase
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = kind;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1; byte_data = q[i];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        check({req, " grant"}, 64'(grant), 64'(eg));
        check({req, " deny"}, 64'(deny), 64'(ed));
        check({req, " copy_done R8"}, 64'(copy_done), 64'(ecd));
        check({req, " aa R8"}, 64'(aa_flag), 64'(eaa));
        m_aa = eaa;
        @(negedge clk);
        check("R9 single pulse", 64'(grant | deny), 64'd0);
        pulse_bus_reset();
    endtask

    initial begin
        logic [63:0] ro_k, rw_k, pat;
        @(negedge clk); @(negedge clk);
        check("R1 grant in reset", 64'(grant), 64'd0);
        check("R1 aa in reset", 64'(aa_flag), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", 64'({grant, deny, copy_done, aa_flag}), 64'd0);

        // R2: bypass with reset enable byte
        run_op(3'd1, 64'hDEAD_BEEF_0123_4567, 0, "R2 read bypass");
        run_op(3'd2, 64'h1111_2222_3333_4444, 0, "R2 copy bypass");
        // R7 and R8: scratchpad commands
        run_op(3'd4, 64'd0, 0, "R7 scratch read");
        run_op(3'd3, 64'd0, 0, "R7 scratch write clears aa R8");
        // R7: unknown command ignored
        run_op(3'd6, 64'd0, 0, "R7 unknown kind");

        ro_k = 64'h0807_0605_0403_0201;
        rw_k = 64'hA1B2_C3D4_E5F6_0718;
        set_key(16'h7FC0, ro_k);
        set_key(16'h7FC8, rw_k);
        // R11: writes beside the map do not enable checking
        st_write(16'h7FD1, 8'hAA);
        st_write(16'h7FBF, 8'hAA);
        run_op(3'd1, 64'h5555_5555_5555_5555, 0, "R11 enable untouched");
        st_write(16'h7FD0, 8'hAA);
        run_op(3'd1, 64'h5555_5555_5555_5555, 0, "R3 wrong pattern denied");
        run_op(3'd1, ro_k, 0, "R3 read with ro key");
        run_op(3'd1, rw_k, 0, "R3 read with rw key");
        run_op(3'd1, ro_k ^ 64'h0100_0000_0000_0000, 0, "R6 last byte differs");
        run_op(3'd1, {ro_k[7:0], ro_k[15:8], ro_k[23:16], ro_k[31:24],
                      ro_k[39:32], ro_k[47:40], ro_k[55:48], ro_k[63:56]}, 0, "R6 byte order");
        run_op(3'd2, ro_k, 0, "R4 copy with ro key");
        run_op(3'd2, rw_k, 0, "R4 copy with rw key");
        run_op(3'd2, rw_k, 1, "R5 echo byte 0 bad");
        run_op(3'd2, rw_k, 2, "R5 echo byte 1 bad");
        run_op(3'd2, rw_k, 3, "R5 echo byte 2 bad");

        // R10: after a decision, traffic is ignored until bus_reset
        @(negedge clk); cmd_valid = 1'b1; cmd_kind = 3'd4;
        @(negedge clk); cmd_valid = 1'b0;
        @(negedge clk); cmd_valid = 1'b1; cmd_kind = 3'd4;
        @(negedge clk); cmd_valid = 1'b0;
        check("R10 held after decision", 64'(grant | deny), 64'd0);
        pulse_bus_reset();
        run_op(3'd4, 64'd0, 0, "R10 idle after bus_reset");

        // Random traffic with fixed seed
        void'($urandom(32'd1977));
        for (int it = 0; it < 300; it++) begin
            int sel = $urandom_range(0, 9);
            int pk = $urandom_range(0, 3);
            logic [2:0] kind = 3'($urandom_range(1, 4));
            if (sel == 0) st_write(16'h7FD0, ($urandom_range(0, 1) != 0) ? 8'hAA : 8'h00);
            if (sel == 1) st_write(16'h7FC0 + 16'($urandom_range(0, 15)), 8'($urandom()));
            ta_addr = 16'($urandom());
            es_low = 7'($urandom());
            case (pk)
                0: pat = m_ro;
                1: pat = m_rw;
                2: pat = {$urandom(), $urandom()};
                default: pat = m_rw ^ (64'hFF << (8 * $urandom_range(0, 7)));
            endcase
            run_op(kind, pat, ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0,
                   "R3 R4 R5 random op");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule